// File: doc/BRIEF.md
# Condition Code Evaluator

This block decides whether an instruction carrying a 4-bit condition field should execute, given the current negative (N), zero (Z), carry (C) and overflow (V) status flags. Besides single-flag tests, it evaluates the compound unsigned comparisons (higher, lower-or-same) and the compound signed comparisons (greater-or-equal, less-than, greater-than, less-or-equal).

The caller presents a condition field and the flags together with a valid strobe. On the next rising clock edge the block registers two results: a pass bit, and an illegal bit that flags the one reserved code. While valid is low, both outputs keep their last values. A synchronous reset clears both.

Top module: `condEvaluator`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears pass and illegal to 0 at that edge.
- R2: pass and illegal update only at a rising edge where valid is high. At an edge where valid is low they keep their previous values, whatever cond and the flags do.
- R3: Code 4'b0000 (equal) passes when Z=1. Code 4'b0001 (not equal) passes when Z=0.
- R4: Code 4'b0010 passes when C=1 and 4'b0011 when C=0. Code 4'b0100 passes when N=1 and 4'b0101 when N=0. Code 4'b0110 passes when V=1 and 4'b0111 when V=0.
- R5: Code 4'b1000 (unsigned higher) passes only when C=1 and Z=0. Code 4'b1001 (unsigned lower or same) passes when C=0 or Z=1.
- R6: Code 4'b1010 (signed greater or equal) passes when N equals V. Code 4'b1011 (signed less than) passes when N differs from V.
- R7: Code 4'b1100 (signed greater than) passes when Z=0 and N equals V. Code 4'b1101 (signed less or equal) passes when Z=1 or N differs from V.
- R8: Code 4'b1110 (always) passes for every flag value.
- R9: Code 4'b1111 (reserved) gives pass=0 and illegal=1 for every flag value.
- R10: illegal is 1 only after a reserved code is loaded, and pass and illegal are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Loads a new evaluation at the next edge |
| cond | input | 4 | Condition field of the instruction |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| flagV | input | 1 | Overflow flag |
| pass | output | 1 | Registered result: the instruction executes |
| illegal | output | 1 | Registered result: the reserved code was seen |

## Verification
The block has no top-level parameters. The bench builds it with the package constants: a 4-bit condition field split into eight code pairs. At that width, all 256 combinations of code and flags can be swept exhaustively against a model written directly from the requirements. A vector table then fixes the boundary cases of the compound signed and unsigned predicates, and directed sequences cover hold-while-idle and reset in the middle of a run.

// File: rtl/condEvalPkg.sv
package condEvalPkg;
  localparam int CondWidth = 4;
  localparam int FlagCount = 4;
  localparam int PairCount = 1 << (CondWidth - 1);

  typedef enum logic [CondWidth-1:0] {
    COND_EQ = 4'b0000, COND_NE = 4'b0001,
    COND_CS = 4'b0010, COND_CC = 4'b0011,
    COND_MI = 4'b0100, COND_PL = 4'b0101,
    COND_VS = 4'b0110, COND_VC = 4'b0111,
    COND_HI = 4'b1000, COND_LS = 4'b1001,
    COND_GE = 4'b1010, COND_LT = 4'b1011,
    COND_GT = 4'b1100, COND_LE = 4'b1101,
    COND_AL = 4'b1110, COND_XX = 4'b1111
  } condCodeT;

  // flag vector layout: [3]=N [2]=Z [1]=C [0]=V
  localparam int FlagN = 3;
  localparam int FlagZ = 2;
  localparam int FlagC = 1;
  localparam int FlagV = 0;

  typedef struct packed {
    logic load;
    logic clear;
  } ctrlStrobeT;
endpackage

// File: rtl/condEvalCtrl.sv
module condEvalCtrl
  import condEvalPkg::*;
(
  input  logic       rst,
  input  logic       valid,
  output ctrlStrobeT strobe
);
  always_comb begin
    strobe.clear = rst;
    strobe.load  = valid && !rst;
  end
endmodule

// File: rtl/condEvalPath.sv
module condEvalPath
  import condEvalPkg::*;
(
  input  logic                 clk,
  input  ctrlStrobeT           strobe,
  input  logic [CondWidth-1:0] cond,
  input  logic [FlagCount-1:0] flags,
  output logic                 pass,
  output logic                 illegal
);
  // Each even code holds the positive predicate; the odd code is its inverse.
  function automatic logic pairBase(input int idx, input logic [FlagCount-1:0] f);
    logic nEqV;
    nEqV = (f[FlagN] == f[FlagV]);
    case (idx)
      0:       return f[FlagZ];
      1:       return f[FlagC];
      2:       return f[FlagN];
      3:       return f[FlagV];
      4:       return f[FlagC] && !f[FlagZ];
      5:       return nEqV;
      6:       return !f[FlagZ] && nEqV;
      default: return 1'b1;
    endcase
  endfunction

  logic [PairCount-1:0] pairHit;

  for (genvar p = 0; p < PairCount; p++) begin : g_pair
    assign pairHit[p] = pairBase(p, flags);
  end

  logic passNext;
  logic illegalNext;

  always_comb begin
    illegalNext = &cond;
    passNext    = pairHit[cond[CondWidth-1:1]] ^ cond[0];
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      pass    <= 1'b0;
      illegal <= 1'b0;
    end else if (strobe.load) begin
      pass    <= passNext;
      illegal <= illegalNext;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    strobe.clear |=> (!pass && !illegal));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.load |=> ($stable(pass) && $stable(illegal)));

  a_r3_equal: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.load && cond == COND_EQ) |=> (pass == $past(flags[FlagZ])));

  a_r5_higher: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.load && cond == COND_HI && flags[FlagZ]) |=> !pass);

  a_r7_greater: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.load && cond == COND_GT && (flags[FlagN] != flags[FlagV])) |=> !pass);

  a_r8_always: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.load && cond == COND_AL) |=> (pass && !illegal));

  a_r9_reserved: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.load && cond == COND_XX) |=> (illegal && !pass));

  a_r10_exclusive: assert property (@(posedge clk)
    !(pass && illegal));
endmodule

// File: rtl/condEvaluator.sv
module condEvaluator
  import condEvalPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       valid,
  input  logic [3:0] cond,
  input  logic       flagN,
  input  logic       flagZ,
  input  logic       flagC,
  input  logic       flagV,
  output logic       pass,
  output logic       illegal
);
  ctrlStrobeT strobe;
  logic [FlagCount-1:0] flags;

  assign flags = {flagN, flagZ, flagC, flagV};

  condEvalCtrl i_ctrl (
    .rst    (rst),
    .valid  (valid),
    .strobe (strobe)
  );

  condEvalPath i_path (
    .clk     (clk),
    .strobe  (strobe),
    .cond    (cond),
    .flags   (flags),
    .pass    (pass),
    .illegal (illegal)
  );
endmodule

// File: tb/test_condEvaluator.sv
module test_condEvaluator;
  logic clk = 1'b0;
  logic rst, valid, flagN, flagZ, flagC, flagV;
  logic [3:0] cond;
  logic pass, illegal;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  condEvaluator i_condEvaluator (
    .clk(clk), .rst(rst), .valid(valid), .cond(cond),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
    .pass(pass), .illegal(illegal)
  );

  // vector: cond[13:10] nzcv[9:6] pass[5] illegal[4]
  localparam int NumVec = 22;
  localparam logic [13:0] Vecs [NumVec] = '{
    {4'b0000, 4'b0100, 1'b1, 1'b0, 4'd0},  // R3 EQ Z=1
    {4'b0000, 4'b1011, 1'b0, 1'b0, 4'd0},  // R3 EQ Z=0
    {4'b0001, 4'b0100, 1'b0, 1'b0, 4'd0},  // R3 NE
    {4'b0010, 4'b0010, 1'b1, 1'b0, 4'd0},  // R4 CS
    {4'b0011, 4'b0010, 1'b0, 1'b0, 4'd0},  // R4 CC
    {4'b0100, 4'b1000, 1'b1, 1'b0, 4'd0},  // R4 MI
    {4'b0101, 4'b1000, 1'b0, 1'b0, 4'd0},  // R4 PL
    {4'b0111, 4'b0000, 1'b1, 1'b0, 4'd0},  // R4 VC
    {4'b1000, 4'b0010, 1'b1, 1'b0, 4'd0},  // R5 HI C=1 Z=0
    {4'b1000, 4'b0110, 1'b0, 1'b0, 4'd0},  // R5 HI C=1 Z=1
    {4'b1001, 4'b0110, 1'b1, 1'b0, 4'd0},  // R5 LS Z=1
    {4'b1001, 4'b0010, 1'b0, 1'b0, 4'd0},  // R5 LS C=1 Z=0
    {4'b1010, 4'b1001, 1'b1, 1'b0, 4'd0},  // R6 GE N=V=1
    {4'b1010, 4'b1000, 1'b0, 1'b0, 4'd0},  // R6 GE N!=V
    {4'b1011, 4'b0001, 1'b1, 1'b0, 4'd0},  // R6 LT
    {4'b1100, 4'b0000, 1'b1, 1'b0, 4'd0},  // R7 GT
    {4'b1100, 4'b0100, 1'b0, 1'b0, 4'd0},  // R7 GT Z=1
    {4'b1101, 4'b0100, 1'b1, 1'b0, 4'd0},  // R7 LE Z=1
    {4'b1101, 4'b1001, 1'b0, 1'b0, 4'd0},  // R7 LE N=V Z=0
    {4'b1110, 4'b0000, 1'b1, 1'b0, 4'd0},  // R8 AL
    {4'b1111, 4'b1111, 1'b0, 1'b1, 4'd0},  // R9 reserved
    {4'b1111, 4'b0000, 1'b0, 1'b1, 4'd0}   // R9 reserved
  };

  function automatic string reqOf(input logic [3:0] c);
    if (c <= 4'd1) return "R3";
    if (c <= 4'd7) return "R4";
    if (c <= 4'd9) return "R5";
    if (c <= 4'd11) return "R6";
    if (c <= 4'd13) return "R7";
    if (c == 4'd14) return "R8";
    return "R9";
  endfunction

  function automatic logic modelPass(input logic [3:0] c, input logic n, z, cy, v);
    case (c)
      4'd0: return z;          4'd1: return !z;
      4'd2: return cy;         4'd3: return !cy;
      4'd4: return n;          4'd5: return !n;
      4'd6: return v;          4'd7: return !v;
      4'd8: return cy && !z;   4'd9: return !cy || z;
      4'd10: return n == v;    4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic actP, expP, actI, expI);
    checks++;
    if (actP !== expP || actI !== expI) begin
      failures++;
      $display("FAIL %s pass=%b illegal=%b expected pass=%b illegal=%b", req, actP, actI, expP, expI);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [3:0] nzcv);
    @(negedge clk);
    cond = c; {flagN, flagZ, flagC, flagV} = nzcv; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; valid = 1'b0; cond = 4'd0; {flagN, flagZ, flagC, flagV} = 4'd0;
    repeat (2) @(negedge clk);
    check("R1", pass, 1'b0, illegal, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NumVec; i++) begin
      apply(Vecs[i][13:10], Vecs[i][9:6]);
      check(reqOf(Vecs[i][13:10]), pass, Vecs[i][5], illegal, Vecs[i][4]);
    end

    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        apply(4'(c), 4'(f));
        check(reqOf(4'(c)), pass, modelPass(4'(c), f[3], f[2], f[1], f[0]),
              illegal, (c == 15));
      end
    end

    // R2: hold while valid low
    apply(4'b1110, 4'b0000);
    cond = 4'b1111; {flagN, flagZ, flagC, flagV} = 4'b1111;
    repeat (3) @(negedge clk);
    check("R2", pass, 1'b1, illegal, 1'b0);
    apply(4'b1111, 4'b0000);
    cond = 4'b1110;
    repeat (3) @(negedge clk);
    check("R2", pass, 1'b0, illegal, 1'b1);

    // R10: illegal drops once a legal code loads
    apply(4'b0001, 4'b0000);
    check("R10", pass, 1'b1, illegal, 1'b0);

    // R1: reset in mid-run clears, and wins over valid
    apply(4'b1110, 4'b0000);
    @(negedge clk);
    rst = 1'b1; valid = 1'b1;
    @(negedge clk);
    check("R1", pass, 1'b0, illegal, 1'b0);
    rst = 1'b0; valid = 1'b0;
    apply(4'b1111, 4'b0000);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", pass, 1'b0, illegal, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule